// File: doc/BRIEF.md
# CRC-Guarded Register Target Engine

This block is the byte-level transaction engine of a bus target whose register accesses are protected by an 8-bit CRC. A bit-level front end, not part of this block, decodes bus traffic into events. Each event is a start or repeated start, a stop, the address byte that follows a start, a received byte, or a request for the next byte to transmit. The engine compares the upper seven bits of the address byte with its own device address. It then decodes a command byte that carries both a burst length and a starting register address, and it moves up to four bytes between the bus and a 64-entry byte-wide register file.

A write burst is taken into a staging buffer. It reaches the register file in a single cycle, and only after two things have happened: the trailing CRC byte has matched, and the dummy byte that closes the frame has arrived. A read is set up by a write-addressed phase that carries only the command byte. A repeated start with the read bit then follows. The engine returns the burst, then a CRC over the read-direction address byte, the command byte and the returned data, and then 0xFF for any further requests. CRC mismatches and malformed write frames raise a sticky error flag, which holds until a dedicated clear input is pulsed.

Top module: `crc_i2c_regtarget`

## Requirements
- R1: The CRC is CRC-8 with polynomial 0x07, shifted MSB first, initial value 0x00 and no final inversion. It is taken over the address byte (device address in bits [7:1], R/W in bit 0, 0 for write and 1 for read), then the command byte, then each data byte.
- R2: In the command byte, bits [5:0] hold the first register address and bits [7:6] hold the burst length minus one, so codes 0..3 move 1..4 bytes.
- R3: A write frame is: the command byte, N data bytes, one CRC byte, one ignored dummy byte. All N bytes are written to the register file together in the cycle after the dummy byte is received, and only if the CRC byte matched.
- R4: If the received CRC byte differs from the computed one, the register file is left unchanged and the error flag is high from the cycle after that byte.
- R5: Register addresses inside a burst increment by one and wrap from 63 to 0, for both writes and reads.
- R6: On a read, the first N transmit requests return register data starting at the commanded address. The next request returns the CRC computed with R/W = 1, and every later request returns 0xFF. When no read is active, tx_byte is 0xFF.
- R7: A start or stop received after the first data byte and before the dummy byte aborts the write without committing it and sets the error flag. A repeated start that follows only the command byte keeps that command for the next read and raises no error.
- R8: Any byte received after the dummy byte of a write frame sets the error flag; the committed data stays.
- R9: The error flag stays high until err_clr is pulsed. If an error is raised in the same cycle as err_clr, the flag stays set.
- R10: addr_hit is high while an address byte whose bits [7:1] equal DEV_ADDR is presented after a start. A frame to any other address has no effect on the registers or the error flag.
- R11: After reset the error flag is low, tx_byte is 0xFF and all registers read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_start | input | 1 | One-cycle pulse: start or repeated start seen |
| bus_stop | input | 1 | One-cycle pulse: stop seen |
| addr_vld | input | 1 | One-cycle pulse: address byte present on addr_byte |
| addr_byte | input | 8 | Address byte, device address in [7:1], R/W in [0] |
| rx_vld | input | 1 | One-cycle pulse: received byte present on rx_byte |
| rx_byte | input | 8 | Received byte |
| tx_req | input | 1 | One-cycle pulse: the byte on tx_byte has been taken |
| tx_byte | output | 8 | Byte to send on the next transmit request |
| addr_hit | output | 1 | Address byte matches this target (acknowledge) |
| err_clr | input | 1 | Clears the sticky error flag |
| err_flag | output | 1 | Sticky CRC / frame-length error |

## Verification
The embedded assertions watch several rules on every cycle. Once set, the error flag holds until a clear arrives. A bad CRC byte always raises it. The register file never changes without a commit. No commit coincides with a start or stop, and none happens after a foreign address. The read index also never passes the CRC position plus one. Three behaviours are shown only by the bench's transaction scenarios: the CRC values themselves, address wrap across register 63, and the exact byte sequence a read returns (data, CRC, then 0xFF). The bench's behavioural model is compared every clock and predicts tx_byte and err_flag across good, corrupted, aborted, over-long and foreign-address frames.

// File: rtl/crcreg_pkg.sv
package crcreg_pkg;

  // Command byte layout: register address in the low bits, length-1 above it.
  localparam int CMD_AW    = 6;
  localparam int LEN_W     = 2;
  localparam int MAX_BURST = 1 << LEN_W;
  localparam int NREGS     = 1 << CMD_AW;
  // Index runs 0..MAX_BURST+1 on reads (data, CRC, then saturated).
  localparam int IDX_W     = $clog2(MAX_BURST + 2);
  localparam logic [7:0] CRC_POLY = 8'h07;

  typedef enum logic [2:0] {
    FS_IDLE,   // waiting for an address byte after start
    FS_SKIP,   // addressed to someone else
    FS_CMD,    // write-addressed, expecting command byte
    FS_DATA,   // collecting write data
    FS_CRC,    // expecting CRC byte
    FS_DUMMY,  // expecting dummy byte (commit point)
    FS_OVER,   // frame complete, further bytes are a length error
    FS_READ    // streaming data / CRC / filler
  } fstate_e;

  function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] din);
    logic [7:0] c;
    c = crc ^ din;
    for (int b = 0; b < 8; b++) begin
      c = {c[6:0], 1'b0} ^ (c[7] ? CRC_POLY : 8'h00);
    end
    return c;
  endfunction

endpackage

// File: rtl/crcreg_regfile.sv
module crcreg_regfile
  import crcreg_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [CMD_AW-1:0]          wr_base,
  input  logic [LEN_W-1:0]           wr_cnt,
  input  logic [MAX_BURST-1:0][7:0]  wr_data,
  input  logic [CMD_AW-1:0]          rd_addr,
  output logic [7:0]                 rd_data
);

  logic [NREGS-1:0][7:0]   mem_q;
  logic [NREGS-1:0][7:0]   mem_d;
  logic [CMD_AW-1:0]       lane_addr [MAX_BURST];
  logic [MAX_BURST-1:0]    lane_en;

  // One write lane per burst position; address wraps by truncation.
  for (genvar k = 0; k < MAX_BURST; k++) begin : g_lane
    assign lane_addr[k] = wr_base + CMD_AW'(k);
    assign lane_en[k]   = wr_en && (LEN_W'(k) <= wr_cnt);
  end

  always_comb begin
    mem_d = mem_q;
    for (int k = 0; k < MAX_BURST; k++) begin
      if (lane_en[k]) mem_d[lane_addr[k]] = wr_data[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else if (wr_en) begin
      mem_q <= mem_d;
    end
  end

  assign rd_data = mem_q[rd_addr];

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mem_q)); // R3

endmodule

// File: rtl/crcreg_frame.sv
module crcreg_frame
  import crcreg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h34
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_start,
  input  logic                       bus_stop,
  input  logic                       addr_vld,
  input  logic [7:0]                 addr_byte,
  input  logic                       rx_vld,
  input  logic [7:0]                 rx_byte,
  input  logic                       tx_req,
  input  logic                       err_clr,
  input  logic [7:0]                 rd_data,
  output logic                       wr_en,
  output logic [CMD_AW-1:0]          wr_base,
  output logic [LEN_W-1:0]           wr_cnt,
  output logic [MAX_BURST-1:0][7:0]  wr_data,
  output logic [CMD_AW-1:0]          rd_addr,
  output logic [7:0]                 tx_byte,
  output logic                       addr_hit,
  output logic                       err_flag
);

  fstate_e                   state_q, state_d;
  logic [7:0]                cmd_q, cmd_d;
  logic [IDX_W-1:0]          cnt_q, cnt_d;
  logic [7:0]                crc_q, crc_d;
  logic                      ok_q, ok_d;
  logic                      err_q, err_d;
  logic [MAX_BURST-1:0][7:0] stage_q, stage_d;
  logic                      stage_we;
  logic                      err_set;
  logic                      commit;
  logic                      dev_match;
  logic                      pending;
  logic [LEN_W-1:0]          len_m1;
  logic [IDX_W-1:0]          len;

  assign len_m1    = cmd_q[CMD_AW +: LEN_W];
  assign len       = IDX_W'(len_m1) + IDX_W'(1);
  assign dev_match = (addr_byte[7:1] == DEV_ADDR);
  assign addr_hit  = addr_vld && (state_q == FS_IDLE) && dev_match;
  assign pending   = ((state_q == FS_DATA) && (cnt_q != '0)) ||
                     (state_q == FS_CRC) || (state_q == FS_DUMMY);

  always_comb begin
    state_d  = state_q;
    cmd_d    = cmd_q;
    cnt_d    = cnt_q;
    crc_d    = crc_q;
    ok_d     = ok_q;
    stage_d  = stage_q;
    stage_we = 1'b0;
    err_set  = 1'b0;
    commit   = 1'b0;
    if (bus_start || bus_stop) begin
      if (pending) err_set = 1'b1;
      state_d = FS_IDLE;
    end else begin
      unique case (state_q)
        FS_IDLE: if (addr_vld) begin
          cnt_d = '0;
          if (!dev_match) begin
            state_d = FS_SKIP;
          end else if (addr_byte[0]) begin
            state_d = FS_READ;
            crc_d   = crc8_step(crc8_step(8'h00, addr_byte), cmd_q);
          end else begin
            state_d = FS_CMD;
            crc_d   = crc8_step(8'h00, addr_byte);
          end
        end
        FS_CMD: if (rx_vld) begin
          cmd_d   = rx_byte;
          crc_d   = crc8_step(crc_q, rx_byte);
          cnt_d   = '0;
          state_d = FS_DATA;
        end
        FS_DATA: if (rx_vld) begin
          stage_we = 1'b1;
          stage_d[cnt_q[LEN_W-1:0]] = rx_byte;
          crc_d = crc8_step(crc_q, rx_byte);
          cnt_d = cnt_q + IDX_W'(1);
          if (cnt_q == IDX_W'(len_m1)) state_d = FS_CRC;
        end
        FS_CRC: if (rx_vld) begin
          ok_d = (rx_byte == crc_q);
          if (rx_byte != crc_q) err_set = 1'b1;
          state_d = FS_DUMMY;
        end
        FS_DUMMY: if (rx_vld) begin
          commit  = ok_q;
          state_d = FS_OVER;
        end
        FS_OVER: if (rx_vld) err_set = 1'b1;
        FS_READ: if (tx_req && (cnt_q <= len)) begin
          if (cnt_q < len) crc_d = crc8_step(crc_q, rd_data);
          cnt_d = cnt_q + IDX_W'(1);
        end
        default: state_d = FS_IDLE;
      endcase
    end
    if (err_set)      err_d = 1'b1;
    else if (err_clr) err_d = 1'b0;
    else              err_d = err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      cmd_q   <= '0;
      cnt_q   <= '0;
      crc_q   <= '0;
      ok_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cmd_q   <= cmd_d;
      cnt_q   <= cnt_d;
      crc_q   <= crc_d;
      ok_q    <= ok_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else if (stage_we) begin
      stage_q <= stage_d;
    end
  end

  assign wr_en    = commit;
  assign wr_base  = cmd_q[CMD_AW-1:0];
  assign wr_cnt   = len_m1;
  assign wr_data  = stage_q;
  assign rd_addr  = cmd_q[CMD_AW-1:0] + CMD_AW'(cnt_q);
  assign err_flag = err_q;

  always_comb begin
    tx_byte = 8'hFF;
    if (state_q == FS_READ) begin
      if (cnt_q < len)       tx_byte = rd_data;
      else if (cnt_q == len) tx_byte = crc_q;
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !err_clr) |=> err_q); // R9
  AST_CRC_FAIL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_vld && !bus_start && !bus_stop && state_q == FS_CRC && rx_byte != crc_q) |=> err_q); // R4
  AST_ABORT_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_start || bus_stop) |-> !wr_en); // R7
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= len + IDX_W'(1)); // R6
  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FS_SKIP) |-> !wr_en); // R10

endmodule

// File: rtl/crc_i2c_regtarget.sv
module crc_i2c_regtarget
  import crcreg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h34
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_start,
  input  logic       bus_stop,
  input  logic       addr_vld,
  input  logic [7:0] addr_byte,
  input  logic       rx_vld,
  input  logic [7:0] rx_byte,
  input  logic       tx_req,
  output logic [7:0] tx_byte,
  output logic       addr_hit,
  input  logic       err_clr,
  output logic       err_flag
);

  logic                      wr_en;
  logic [CMD_AW-1:0]         wr_base;
  logic [LEN_W-1:0]          wr_cnt;
  logic [MAX_BURST-1:0][7:0] wr_data;
  logic [CMD_AW-1:0]         rd_addr;
  logic [7:0]                rd_data;

  crcreg_frame #(.DEV_ADDR(DEV_ADDR)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_start (bus_start),
    .bus_stop  (bus_stop),
    .addr_vld  (addr_vld),
    .addr_byte (addr_byte),
    .rx_vld    (rx_vld),
    .rx_byte   (rx_byte),
    .tx_req    (tx_req),
    .err_clr   (err_clr),
    .rd_data   (rd_data),
    .wr_en     (wr_en),
    .wr_base   (wr_base),
    .wr_cnt    (wr_cnt),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .tx_byte   (tx_byte),
    .addr_hit  (addr_hit),
    .err_flag  (err_flag)
  );

  crcreg_regfile u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_base (wr_base),
    .wr_cnt  (wr_cnt),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

endmodule

// File: tb/crc_i2c_regtarget_bench.sv
`timescale 1ns/1ps
module crc_i2c_regtarget_bench;

  localparam logic [6:0] DEV = 7'h34;
  localparam logic [7:0] AW_BYTE = {DEV, 1'b0};
  localparam logic [7:0] AR_BYTE = {DEV, 1'b1};

  typedef logic [7:0] bq_t[$];

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_start, bus_stop, addr_vld, rx_vld, tx_req, err_clr;
  logic [7:0] addr_byte, rx_byte;
  logic [7:0] tx_byte;
  logic       addr_hit, err_flag;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit started = 0;

  always #4 clk = ~clk;

  crc_i2c_regtarget #(.DEV_ADDR(DEV)) u_crc_i2c_regtarget (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
    .addr_vld(addr_vld), .addr_byte(addr_byte), .rx_vld(rx_vld), .rx_byte(rx_byte),
    .tx_req(tx_req), .tx_byte(tx_byte), .addr_hit(addr_hit),
    .err_clr(err_clr), .err_flag(err_flag)
  );

  // Bit-serial CRC over a byte list (R1).
  function automatic logic [7:0] ref_crc(input bq_t q);
    logic [7:0] c = 8'h00;
    foreach (q[i]) begin
      for (int b = 7; b >= 0; b--) begin
        logic fb;
        fb = c[7] ^ q[i][b];
        c  = c << 1;
        if (fb) c = c ^ 8'h07;
      end
    end
    return c;
  endfunction

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int         m_mode;     // 0 idle, 1 foreign, 2 write, 3 read
  logic [7:0] m_regs [64];
  logic [7:0] m_cmd, m_raddr;
  bit         m_err, m_ok;
  int         m_ridx;
  bq_t        m_q;

  function automatic int m_len();
    return int'(m_cmd[7:6]) + 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_err = 0; m_ok = 0; m_cmd = 0; m_raddr = 0; m_ridx = 0;
      m_q.delete();
      for (int i = 0; i < 64; i++) m_regs[i] = 8'h00;
    end else begin
      bit setf;
      setf = 0;
      if (bus_start || bus_stop) begin
        if (m_mode == 2 && m_q.size() > 2 && m_q.size() < m_len() + 4) setf = 1;
        m_mode = 0;
        m_q.delete();
      end else if (m_mode == 0 && addr_vld) begin
        if (addr_byte[7:1] != DEV) m_mode = 1;
        else if (addr_byte[0]) begin m_mode = 3; m_ridx = 0; m_raddr = addr_byte; end
        else begin m_mode = 2; m_q.delete(); m_q.push_back(addr_byte); end
      end else if (m_mode == 2 && rx_vld) begin
        int n;
        m_q.push_back(rx_byte);
        n = m_q.size();
        if (n == 2) m_cmd = rx_byte;
        if (n == m_len() + 3) begin
          bq_t body;
          body = m_q[0:n-2];
          m_ok = (ref_crc(body) == rx_byte);
          if (!m_ok) setf = 1;
        end else if (n == m_len() + 4) begin
          if (m_ok)
            for (int k = 0; k < m_len(); k++)
              m_regs[(int'(m_q[1][5:0]) + k) % 64] = m_q[2 + k];
        end else if (n > m_len() + 4) begin
          setf = 1;
        end
      end else if (m_mode == 3 && tx_req) begin
        if (m_ridx <= m_len()) m_ridx++;
      end
      if (setf) m_err = 1;
      else if (err_clr) m_err = 0;
    end
  end

  function automatic logic [7:0] m_tx();
    bq_t q;
    if (m_mode != 3) return 8'hFF;
    if (m_ridx < m_len()) return m_regs[(int'(m_cmd[5:0]) + m_ridx) % 64];
    if (m_ridx == m_len()) begin
      q.push_back(m_raddr);
      q.push_back(m_cmd);
      for (int k = 0; k < m_len(); k++) q.push_back(m_regs[(int'(m_cmd[5:0]) + k) % 64]);
      return ref_crc(q);
    end
    return 8'hFF;
  endfunction

  // Every-clock comparison away from the active edge.
  always @(negedge clk) begin
    if (started && rst_n) begin
      check8("R6 tx_byte vs model", tx_byte, m_tx());
      check8("R9 err_flag vs model", {7'd0, err_flag}, {7'd0, m_err});
    end
  end

  // Watchdog.
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<=100000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // ---------------- stimulus tasks ----------------
  logic       last_hit;
  bq_t        rd_got;

  task automatic tick;
    @(posedge clk); #2;
  endtask
  task automatic do_start; bus_start = 1; tick; bus_start = 0; endtask
  task automatic do_stop;  bus_stop  = 1; tick; bus_stop  = 0; endtask
  task automatic send_addr(input logic [7:0] b);
    addr_byte = b; addr_vld = 1; #1 last_hit = addr_hit; tick; addr_vld = 0;
  endtask
  task automatic send_rx(input logic [7:0] b);
    rx_byte = b; rx_vld = 1; tick; rx_vld = 0;
  endtask
  task automatic pulse_clr; err_clr = 1; tick; err_clr = 0; endtask

  task automatic wr_frame(input logic [7:0] abyte, input logic [5:0] a, input bq_t d,
                          input bit bad, input bit extra, input bit clr_at_crc);
    logic [7:0] cmd, c;
    bq_t q;
    cmd = {2'(d.size() - 1), a};
    q.push_back(abyte); q.push_back(cmd);
    foreach (d[i]) q.push_back(d[i]);
    c = ref_crc(q) ^ (bad ? 8'h01 : 8'h00);
    do_start;
    send_addr(abyte);
    send_rx(cmd);
    foreach (d[i]) send_rx(d[i]);
    err_clr = clr_at_crc;
    send_rx(c);
    err_clr = 0;
    send_rx(8'h00);
    if (extra) send_rx(8'h5A);
    do_stop;
  endtask

  task automatic rd_frame(input logic [5:0] a, input int n, input int nreq);
    rd_got.delete();
    do_start;
    send_addr(AW_BYTE);
    send_rx({2'(n - 1), a});
    do_start;
    send_addr(AR_BYTE);
    for (int i = 0; i < nreq; i++) begin
      rd_got.push_back(tx_byte);
      tx_req = 1; tick; tx_req = 0;
    end
    do_stop;
  endtask

  function automatic logic [7:0] rd_crc(input logic [7:0] cmd, input bq_t d);
    bq_t q;
    q.push_back(AR_BYTE); q.push_back(cmd);
    foreach (d[i]) q.push_back(d[i]);
    return ref_crc(q);
  endfunction

  initial begin
    bq_t d;
    rst_n = 0; bus_start = 0; bus_stop = 0; addr_vld = 0; rx_vld = 0; tx_req = 0;
    err_clr = 0; addr_byte = 0; rx_byte = 0; last_hit = 0;
    repeat (4) @(posedge clk);
    #2 rst_n = 1;
    started = 1;
    tick;

    // R11: reset state
    check8("R11 err after reset", {7'd0, err_flag}, 8'h00);
    check8("R11 tx idle after reset", tx_byte, 8'hFF);
    rd_frame(6'h00, 4, 5);
    for (int i = 0; i < 4; i++) check8("R11 reset register value", rd_got[i], 8'h00);
    check8("R1 crc of zero read", rd_got[4], rd_crc(8'hC0, '{8'h00, 8'h00, 8'h00, 8'h00}));
    check8("R7 command-only phase then read: no error", {7'd0, err_flag}, 8'h00);

    // R3 / R2 / R6: 4-byte write, read with extra requests
    d = '{8'hA1, 8'hB2, 8'hC3, 8'hD4};
    wr_frame(AW_BYTE, 6'h10, d, 0, 0, 0);
    check8("R3 no error on good write", {7'd0, err_flag}, 8'h00);
    rd_frame(6'h10, 4, 7);
    for (int i = 0; i < 4; i++) check8("R3 written data read back", rd_got[i], d[i]);
    check8("R6 read crc uses R/W=1", rd_got[4], rd_crc(8'hD0, d));
    check8("R6 filler after crc", rd_got[5], 8'hFF);
    check8("R6 filler stays", rd_got[6], 8'hFF);

    // R2: single-byte burst, and a 2-byte read in the middle of the block
    wr_frame(AW_BYTE, 6'h05, '{8'h3C}, 0, 0, 0);
    rd_frame(6'h05, 1, 3);
    check8("R2 length code 0 moves one byte", rd_got[0], 8'h3C);
    check8("R2 crc follows single byte", rd_got[1], rd_crc(8'h05, '{8'h3C}));
    rd_frame(6'h11, 2, 2);
    check8("R2 two-byte read first", rd_got[0], 8'hB2);
    check8("R2 two-byte read second", rd_got[1], 8'hC3);

    // R5: wrap across register 63
    wr_frame(AW_BYTE, 6'h3F, '{8'h11, 8'h22}, 0, 0, 0);
    rd_frame(6'h3E, 3, 4);
    check8("R5 reg 3E", rd_got[0], 8'h00);
    check8("R5 reg 3F", rd_got[1], 8'h11);
    check8("R5 wrapped to reg 00", rd_got[2], 8'h22);

    // R4: bad CRC leaves registers, sets error; R9 sticky then clear
    wr_frame(AW_BYTE, 6'h20, '{8'h99}, 1, 0, 0);
    check8("R4 error after bad crc", {7'd0, err_flag}, 8'h01);
    rd_frame(6'h20, 1, 1);
    check8("R4 register untouched", rd_got[0], 8'h00);
    check8("R9 error still set", {7'd0, err_flag}, 8'h01);
    pulse_clr;
    check8("R9 error cleared", {7'd0, err_flag}, 8'h00);

    // R9: set wins over a simultaneous clear
    wr_frame(AW_BYTE, 6'h21, '{8'h77}, 1, 0, 1);
    check8("R9 set wins over clear", {7'd0, err_flag}, 8'h01);
    pulse_clr;

    // R7: start after first data byte aborts
    do_start; send_addr(AW_BYTE); send_rx({2'b01, 6'h30}); send_rx(8'hEE);
    do_start; do_stop;
    check8("R7 abort sets error", {7'd0, err_flag}, 8'h01);
    pulse_clr;
    rd_frame(6'h30, 2, 2);
    check8("R7 aborted write not committed", rd_got[0], 8'h00);
    check8("R7 aborted write second byte", rd_got[1], 8'h00);

    // R8: extra byte after dummy
    wr_frame(AW_BYTE, 6'h08, '{8'h42, 8'h43, 8'h44}, 0, 1, 0);
    check8("R8 extra byte sets error", {7'd0, err_flag}, 8'h01);
    pulse_clr;
    rd_frame(6'h08, 3, 3);
    check8("R8 data kept", rd_got[2], 8'h44);

    // R10: foreign address ignored, hit reporting
    wr_frame(8'hA0, 6'h10, '{8'h01, 8'h02}, 0, 1, 0);
    check8("R10 foreign address not acknowledged", {7'd0, last_hit}, 8'h00);
    check8("R10 foreign frame no error", {7'd0, err_flag}, 8'h00);
    rd_frame(6'h10, 2, 2);
    check8("R10 own address acknowledged", {7'd0, last_hit}, 8'h01);
    check8("R10 registers unchanged", rd_got[0], 8'hA1);
    check8("R10 registers unchanged 2", rd_got[1], 8'hB2);

    repeat (4) tick;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule